// File: doc/BRIEF.md
# Host Bus Takeover Controller

This block lets a host controller borrow the memory bus of a target CPU and keep control of that CPU's reset line. It takes one command at a time from the host: Reset, Request, Release, Run, Restart or M_Cycle. It drives an active-low bus request and samples the target's active-low bus acknowledge through a synchronizer. It also drives the target reset line and produces one enable for the address and strobe drivers. The memory read and write cycles themselves happen elsewhere, while this block reports that it owns the bus.

The block combines two independent facts into one 2-bit state: whether the target is held in reset or running, and whether the host owns the bus. A wait for acknowledge is bounded by a tick-based timeout. What happens on timeout depends on the state the request started from. Reset pulses have a fixed length counted in clock cycles. The active level of the reset line is learned once, in the first cycle after power-on reset, by sampling the pad before the block starts driving it.

Top module: `bus_takeover`

## Requirements
- R1: In the first clock after `rst_ni` rises, the block samples `rst_pin_i` and takes that level as the active reset level. From then on `rst_oe_o` stays high and `rst_o` shows the active level. While `rst_ni` is low, `rst_oe_o` is low.
- R2: Command code 0 (Reset), from any state, clears `bus_oe_o`, drives reset active and sets `busreq_no` high. `state_o` becomes 0. The state codes are: 0 means held in reset and not owned; 1 means held and owned; 2 means running and not owned; 3 means running and owned.
- R3: Command code 1 (Request) in state 0 drives `busreq_no` low and reset inactive, then waits for acknowledge. When acknowledge arrives, `bus_oe_o` goes high and the state becomes 1.
- R4: If a Request made in state 0 sees no acknowledge within about TIMEOUT_TICKS×TICK_CYCLES cycles, reset goes active again, `busreq_no` goes high and the state stays 0.
- R5: Request in state 2 drives `busreq_no` low. On acknowledge the state becomes 3 with `bus_oe_o` high. On timeout `busreq_no` returns high, the state stays 2 and reset stays inactive.
- R6: Command code 2 (Release) in state 1 goes to state 0 with reset active. In state 3 it goes to state 2. Both clear `bus_oe_o` and set `busreq_no` high.
- R7: Command code 3 (Run) in state 0 drives reset inactive and goes to state 2. In state 1 it clears `bus_oe_o`, gives a reset pulse, then sets `bus_oe_o` again and ends in state 3.
- R8: Command code 4 (Restart) in state 2 or 3 drives reset active for exactly PULSE_CYCLES cycles and leaves the state unchanged.
- R9: Command code 5 (M_Cycle) in state 3 clears `bus_oe_o` and raises `busreq_no` until acknowledge goes high. It then requests the bus again. On acknowledge `bus_oe_o` is set and the state stays 3.
- R10: A command with no action in the current state leaves the state and the outputs unchanged. These are: Request in 1 or 3, Release in 0 or 2, Run in 2 or 3, Restart in 0 or 1, M_Cycle in 0, 1 or 2, and codes 6 and 7.
- R11: `busy_o` is high during setup, while waiting for acknowledge and during a reset pulse. A command presented while `busy_o` is high is ignored.
- R12: `bus_oe_o` is high only while `busreq_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, taken when busy_o is low |
| cmd_i | input | 3 | Command code (0 Reset, 1 Request, 2 Release, 3 Run, 4 Restart, 5 M_Cycle) |
| busy_o | output | 1 | Setup, acknowledge wait or reset pulse in progress |
| state_o | output | 2 | Bit 1 = running, bit 0 = bus owned |
| busreq_no | output | 1 | Bus request to the target, active low |
| busack_ni | input | 1 | Bus acknowledge from the target, active low, asynchronous |
| rst_pin_i | input | 1 | Level of the target reset pad, sampled once at setup |
| rst_o | output | 1 | Level driven onto the target reset pad |
| rst_oe_o | output | 1 | Drive enable for the target reset pad |
| bus_oe_o | output | 1 | Enable for the address and strobe drivers |

## Verification
The bench uses a 4-cycle tick, a 5-tick timeout and a 6-cycle reset pulse. With these values a full acknowledge timeout lasts about 21 cycles, so both timeout paths and their exact durations can be measured cycle by cycle. The same holds for pulse lengths. The acknowledge model follows the request after three cycles, or stays silent. This covers successful takeovers and timeouts, as well as the release-and-reacquire handshake of M_Cycle. A second power-on reset with the pad sampled high tests the inverted reset polarity.

// File: rtl/bus_takeover_pkg.sv
package bus_takeover_pkg;

  typedef enum logic [1:0] {
    ST_HELD     = 2'd0,
    ST_HELD_OWN = 2'd1,
    ST_RUN      = 2'd2,
    ST_RUN_OWN  = 2'd3
  } tk_state_e;

  typedef enum logic [2:0] {
    CMD_RESET   = 3'd0,
    CMD_REQUEST = 3'd1,
    CMD_RELEASE = 3'd2,
    CMD_RUN     = 3'd3,
    CMD_RESTART = 3'd4,
    CMD_MCYCLE  = 3'd5
  } tk_cmd_e;

  typedef enum logic [2:0] {
    PH_SETUP,
    PH_IDLE,
    PH_ACK,
    PH_PULSE,
    PH_MC_REL
  } tk_phase_e;

endpackage

// File: rtl/bus_takeover_sync.sv
module bus_takeover_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RESET_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/bus_takeover_tick.sv
module bus_takeover_tick #(
  parameter int unsigned TICK_CYCLES = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(TICK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST) && !clear_i;
endmodule

// File: rtl/bus_takeover_down_cnt.sv
module bus_takeover_down_cnt #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (dec_i && |cnt_q)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bus_takeover.sv
module bus_takeover
  import bus_takeover_pkg::*;
#(
  parameter int unsigned TICK_CYCLES   = 5_000_000,
  parameter int unsigned TIMEOUT_TICKS = 20,
  parameter int unsigned PULSE_CYCLES  = 500,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  output logic       busy_o,
  output logic [1:0] state_o,
  output logic       busreq_no,
  input  logic       busack_ni,
  input  logic       rst_pin_i,
  output logic       rst_o,
  output logic       rst_oe_o,
  output logic       bus_oe_o
);
  localparam int unsigned TOW = $clog2(TIMEOUT_TICKS + 1);
  localparam int unsigned PLW = $clog2(PULSE_CYCLES + 1);

  tk_state_e st_q;
  tk_phase_e ph_q;
  logic pol_q, rst_act_q, rst_oe_q, busreq_n_q, bus_oe_q, reopen_q;
  logic ack_hi, tick, to_zero, pl_zero, to_ld, pl_ld, idle_cmd;

  bus_takeover_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ack_sync (
    .clk_i, .rst_ni, .d_i(busack_ni), .q_o(ack_hi)
  );

  bus_takeover_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i, .rst_ni, .clear_i(to_ld), .tick_o(tick)
  );

  bus_takeover_down_cnt #(.WIDTH(TOW)) u_to_cnt (
    .clk_i, .rst_ni, .load_i(to_ld), .load_val_i(TOW'(TIMEOUT_TICKS)),
    .dec_i(tick && ph_q == PH_ACK), .zero_o(to_zero)
  );

  bus_takeover_down_cnt #(.WIDTH(PLW)) u_pl_cnt (
    .clk_i, .rst_ni, .load_i(pl_ld), .load_val_i(PLW'(PULSE_CYCLES - 1)),
    .dec_i(ph_q == PH_PULSE), .zero_o(pl_zero)
  );

  assign idle_cmd = (ph_q == PH_IDLE) && cmd_valid_i;

  always_comb begin
    to_ld = 1'b0;
    pl_ld = 1'b0;
    if (idle_cmd) begin
      unique case (cmd_i)
        CMD_REQUEST: to_ld = (st_q == ST_HELD) || (st_q == ST_RUN);
        CMD_RUN:     pl_ld = (st_q == ST_HELD_OWN);
        CMD_RESTART: pl_ld = st_q[1];
        default: ;
      endcase
    end
    if (ph_q == PH_MC_REL && ack_hi) to_ld = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HELD;
      ph_q       <= PH_SETUP;
      pol_q      <= 1'b0;
      rst_act_q  <= 1'b1;
      rst_oe_q   <= 1'b0;
      busreq_n_q <= 1'b1;
      bus_oe_q   <= 1'b0;
      reopen_q   <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_SETUP: begin
          pol_q    <= rst_pin_i;
          rst_oe_q <= 1'b1;
          ph_q     <= PH_IDLE;
        end
        PH_IDLE: if (cmd_valid_i) begin
          unique case (cmd_i)
            CMD_RESET: begin
              bus_oe_q   <= 1'b0;
              rst_act_q  <= 1'b1;
              busreq_n_q <= 1'b1;
              st_q       <= ST_HELD;
            end
            CMD_REQUEST: if (st_q == ST_HELD || st_q == ST_RUN) begin
              busreq_n_q <= 1'b0;
              rst_act_q  <= 1'b0;
              ph_q       <= PH_ACK;
            end
            CMD_RELEASE: if (st_q[0]) begin
              bus_oe_q   <= 1'b0;
              busreq_n_q <= 1'b1;
              if (st_q == ST_HELD_OWN) begin
                rst_act_q <= 1'b1;
                st_q      <= ST_HELD;
              end else begin
                st_q      <= ST_RUN;
              end
            end
            CMD_RUN: begin
              if (st_q == ST_HELD) begin
                rst_act_q <= 1'b0;
                st_q      <= ST_RUN;
              end else if (st_q == ST_HELD_OWN) begin
                bus_oe_q  <= 1'b0;
                rst_act_q <= 1'b1;
                reopen_q  <= 1'b1;
                st_q      <= ST_RUN_OWN;
                ph_q      <= PH_PULSE;
              end
            end
            CMD_RESTART: if (st_q[1]) begin
              rst_act_q <= 1'b1;
              reopen_q  <= 1'b0;
              ph_q      <= PH_PULSE;
            end
            CMD_MCYCLE: if (st_q == ST_RUN_OWN) begin
              bus_oe_q   <= 1'b0;
              busreq_n_q <= 1'b1;
              ph_q       <= PH_MC_REL;
            end
            default: ;
          endcase
        end
        PH_ACK: begin
          if (!ack_hi) begin
            bus_oe_q <= 1'b1;
            st_q     <= tk_state_e'({st_q[1], 1'b1});
            ph_q     <= PH_IDLE;
          end else if (to_zero) begin
            ph_q <= PH_IDLE;
            // origin decides the failure path; an M_Cycle retry keeps its request
            if (st_q == ST_HELD) begin
              rst_act_q  <= 1'b1;
              busreq_n_q <= 1'b1;
            end else if (st_q == ST_RUN) begin
              busreq_n_q <= 1'b1;
            end
          end
        end
        PH_PULSE: if (pl_zero) begin
          rst_act_q <= 1'b0;
          if (reopen_q) bus_oe_q <= 1'b1;
          ph_q <= PH_IDLE;
        end
        PH_MC_REL: if (ack_hi) begin
          busreq_n_q <= 1'b0;
          ph_q       <= PH_ACK;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign state_o   = st_q;
  assign busreq_no = busreq_n_q;
  assign rst_o     = rst_act_q ? pol_q : ~pol_q;
  assign rst_oe_o  = rst_oe_q;
  assign bus_oe_o  = bus_oe_q;
endmodule

// File: rtl/bus_takeover_chk.sv
module bus_takeover_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic       busy_o,
  input logic [1:0] state_o,
  input logic       busreq_no,
  input logic       bus_oe_o,
  input logic       rst_o,
  input logic       rst_oe_o,
  input logic       pol_q
);
  assert_oe_needs_req_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !busreq_no);

  assert_drive_kept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(rst_oe_o));

  assert_held_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && state_o == 2'd0) |-> (rst_o == pol_q && busreq_no && !bus_oe_o));

  assert_run_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && state_o == 2'd2) |-> (rst_o != pol_q && busreq_no && !bus_oe_o));

  assert_pulse_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_oe_o && state_o[1] && rst_o == pol_q) |-> busy_o);

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_valid_i) |=> $stable(state_o));
endmodule

bind bus_takeover bus_takeover_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .busy_o(busy_o),
  .state_o(state_o), .busreq_no(busreq_no), .bus_oe_o(bus_oe_o),
  .rst_o(rst_o), .rst_oe_o(rst_oe_o), .pol_q(pol_q)
);

// File: tb/tb_bus_takeover.sv
`timescale 1ns/1ps
module tb_bus_takeover;
  localparam int TICK = 4, TO = 5, PL = 6;
  localparam int TO_CYC = TICK * TO;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic busy, busreq_n, rst_pin = 1'b0, rst_out, rst_oe, bus_oe;
  logic [1:0] state;
  logic ack_auto = 1'b0;
  logic [2:0] dly = 3'b111;
  logic busack_n;
  logic pol = 1'b0;
  int errors = 0, checks = 0, wd = 0;
  int n, act;

  always #10 clk = ~clk;

  always @(posedge clk) dly <= {dly[1:0], busreq_n};
  assign busack_n = ack_auto ? dly[2] : 1'b1;

  bus_takeover #(.TICK_CYCLES(TICK), .TIMEOUT_TICKS(TO), .PULSE_CYCLES(PL),
                 .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .busy_o(busy), .state_o(state), .busreq_no(busreq_n), .busack_ni(busack_n),
    .rst_pin_i(rst_pin), .rst_o(rst_out), .rst_oe_o(rst_oe), .bus_oe_o(bus_oe)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic chk_out(input string tag, input int st, input bit ract, input bit req_n, input bit oe);
    chk(state == 2'(st), {tag, " state"}, state, st);
    chk((rst_out == pol) == ract, {tag, " reset active"}, (rst_out == pol), ract);
    chk(busreq_n == req_n, {tag, " busreq_n"}, busreq_n, req_n);
    chk(bus_oe == oe, {tag, " bus_oe"}, bus_oe, oe);
  endtask

  task automatic issue(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // issue, then count busy cycles and reset-active cycles while busy
  task automatic run_cmd(input logic [2:0] c, output int nb, output int na);
    issue(c);
    nb = 0; na = 0;
    while (busy && nb < 1000) begin
      nb++;
      if (rst_out == pol) na++;
      @(negedge clk);
    end
  endtask

  task automatic power_on(input bit pin);
    rst_n = 1'b0;
    rst_pin = pin;
    pol = pin;
    repeat (3) @(negedge clk);
    chk(rst_oe == 1'b0, "R1 oe during reset", rst_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rst_oe == 1'b1, "R1 oe after setup", rst_oe, 1);
    chk(busy == 1'b0, "R11 busy after setup", busy, 0);
    chk_out("R1 setup", 0, 1, 1, 0);
  endtask

  task automatic t_ignored(input int st, input logic [2:0] c);
    bit ra, rq, oe;
    ra = (rst_out == pol); rq = busreq_n; oe = bus_oe;
    issue(c);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R10 no busy", busy, 0);
    chk_out("R10 ignored", st, ra, rq, oe);
  endtask

  task automatic t_req_held_timeout;
    ack_auto = 1'b0;
    issue(3'd1);
    chk(busreq_n == 1'b0 && rst_out != pol, "R3 request drives", busreq_n, 0);
    n = 1;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n >= TO_CYC && n <= TO_CYC + 3, "R4 timeout length", n, TO_CYC + 1);
    chk_out("R4 after timeout", 0, 1, 1, 0);
  endtask

  task automatic t_req_ok(input int from, input int to);
    ack_auto = 1'b1;
    run_cmd(3'd1, n, act);
    chk(n < TO_CYC, "R3 R5 ack before timeout", n, TO_CYC);
    chk_out("R3 R5 acquired", to, 0, 0, 1);
  endtask

  task automatic t_run_from_own;
    ack_auto = 1'b1;
    issue(3'd3);
    chk(bus_oe == 1'b0 && rst_out == pol, "R7 pulse floats bus", bus_oe, 0);
    issue(3'd2); // arrives while busy: ignored
    while (busy) @(negedge clk);
    chk_out("R7 R11 run from owned", 3, 0, 0, 1);
  endtask

  task automatic t_restart(input int st, input bit oe);
    run_cmd(3'd4, n, act);
    chk(act == PL, "R8 pulse width", act, PL);
    chk_out("R8 after restart", st, 0, st == 2, oe);
  endtask

  task automatic t_mcycle;
    ack_auto = 1'b1;
    issue(3'd5);
    chk(bus_oe == 1'b0 && busreq_n == 1'b1, "R9 release phase", busreq_n, 1);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk_out("R9 reacquired", 3, 0, 0, 1);
  endtask

  task automatic t_req_run_timeout;
    ack_auto = 1'b0;
    run_cmd(3'd1, n, act);
    chk(n >= TO_CYC && n <= TO_CYC + 3, "R5 timeout length", n, TO_CYC + 1);
    chk_out("R5 after timeout", 2, 0, 1, 0);
  endtask

  initial begin
    power_on(1'b0);
    t_ignored(0, 3'd2); t_ignored(0, 3'd4); t_ignored(0, 3'd5); t_ignored(0, 3'd7);
    t_req_held_timeout();
    t_req_ok(0, 1);
    t_ignored(1, 3'd1); t_ignored(1, 3'd4); t_ignored(1, 3'd5);
    run_cmd(3'd2, n, act);
    chk_out("R6 release held", 0, 1, 1, 0);
    t_req_ok(0, 1);
    t_run_from_own();
    t_ignored(3, 3'd1); t_ignored(3, 3'd3);
    t_restart(3, 1'b1);
    t_mcycle();
    run_cmd(3'd2, n, act);
    chk_out("R6 release running", 2, 0, 1, 0);
    t_ignored(2, 3'd2); t_ignored(2, 3'd3); t_ignored(2, 3'd5);
    t_restart(2, 1'b0);
    t_req_run_timeout();
    t_req_ok(2, 3);
    run_cmd(3'd0, n, act);
    chk_out("R2 reset from owned", 0, 1, 1, 0);
    run_cmd(3'd3, n, act);
    chk_out("R7 run from held", 2, 0, 1, 0);
    run_cmd(3'd0, n, act);
    chk_out("R2 reset from running", 0, 1, 1, 0);
    power_on(1'b1);
    chk(rst_out == 1'b1, "R1 high active level", rst_out, 1);
    run_cmd(3'd3, n, act);
    chk(rst_out == 1'b0, "R1 high polarity inactive", rst_out, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule